// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block lets clocked logic use a 1024-word by 4-bit asynchronous static RAM whose data pins are shared between reading and writing. A host hands it one access at a time: a read or a write, a 10-bit word address and, for writes, a 4-bit value. The controller then drives the memory's address lines, its active-low select and its active-low write strobe, and switches its own bus driver on and off. It stretches every phase over a whole number of clock cycles. Each count is worked out at elaboration from the clock period and the nanosecond figures of the memory's speed grade, rounded up, and is never less than one.

Requests use a valid/ready handshake. `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. After that the host must hold nothing, and the controller lowers `req_ready` until the access has finished. The host may leave `req_valid` high with the next request while the controller is busy. That request simply waits. Completion is reported by a one-cycle pulse on `rsp_valid`, which has no back-pressure. For a read, `rsp_rdata` carries the word during that pulse and holds it until the next read completes.

Between accesses the select line stays high, so the memory sits in its low-power standby state.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_cs_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: Whenever `req_ready` is high, `mem_cs_n` is high (standby when idle).
- R3: A write of value D to address A (bits [9:0]) followed by a read of A returns D in `rsp_rdata`. This holds for every one of the 1024 addresses.
- R4: A write holds `mem_we_n` low for exactly NP cycles, where NP = max(ceil(T_WP/T), ceil(T_WZ/T)+ceil(T_DW/T), ceil(T_AW/T)-1) and T is the clock period. `mem_cs_n` is low throughout, and the write completes (`rsp_valid`) max(NP+2, ceil(T_CYC/T)) cycles after acceptance.
- R5: `mem_dq_oe` is high only while `mem_we_n` is low, rises exactly ceil(T_WZ/T) cycles after `mem_we_n` falls, and falls on the same edge that raises `mem_we_n`. The driven data therefore stays valid for at least T_DW before the write ends.
- R6: `mem_addr` changes only while `mem_we_n` is high, and it is stable for the whole time `mem_cs_n` and `mem_we_n` are both low.
- R7: A read captures `mem_dq_in` at the end of ceil(T_AA/T) cycles with `mem_cs_n` low and the address stable. It completes max(ceil(T_AA/T), ceil(T_CYC/T)) cycles after acceptance.
- R8: `rsp_valid` is a single-cycle pulse, and `req_ready` is low from the cycle after acceptance until `rsp_valid`.
- R9: Two consecutive acceptances are at least ceil(T_CYC/T) cycles apart.
- R10: A request held valid while the controller is busy is not taken until the current access has completed. It is taken in the first idle cycle, and the earlier access is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word address |
| req_wdata | input | 4 | Write value |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 4 | Read value, valid with `rsp_valid` after a read |
| mem_addr | output | 10 | Memory address lines |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_oe | output | 1 | Enable for the controller's bus driver |
| mem_dq_out | output | 4 | Value the controller drives onto the bus |
| mem_dq_in | input | 4 | Value seen on the shared bus |

## Verification
The bench builds the controller with its default parameters: an 8 ns clock and the fastest speed grade (200 ns cycle, 180 ns pulse, 120 ns data setup, 60 ns bus turn-off, 200 ns access). These settings give a 23-cycle strobe, an 8-cycle driver delay and 25-cycle accesses, which is the corner where the pulse, data-setup and turn-off limits all meet exactly with no slack. At this size a full write-then-read sweep of all 1024 addresses fits easily in the run. A timed memory model polls the pins every nanosecond. It poisons read data that is taken too early, flags bus contention, and measures every strobe, so a rounding error of even one cycle shows up as a failure.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSET   = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WREC   = 3'd3,
    ST_RD     = 3'd4,
    ST_GAP    = 3'd5
  } seq_st_t;

  // Round a nanosecond interval up to whole clock cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  // Loaded with N on entry to a phase, so the phase lasts N cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CNT_W'(1));

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int NP     = 23,
  parameter int NAA    = 25,
  parameter int NGAP_W = 0,
  parameter int NGAP_R = 0,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_last,
  output seq_st_t          st,
  output logic             req_ready,
  output logic             accept,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             rd_cap,
  output logic             done
);

  localparam bit HAS_GAP_W = (NGAP_W > 0);
  localparam bit HAS_GAP_R = (NGAP_R > 0);

  seq_st_t st_nxt;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign rd_cap    = (st == ST_RD) && tmr_last;

  always_comb begin
    st_nxt   = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    done     = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (req_valid) begin
          tmr_load = 1'b1;
          if (req_write) begin
            st_nxt  = ST_WSET;
            tmr_val = CNT_W'(1);
          end else begin
            st_nxt  = ST_RD;
            tmr_val = CNT_W'(NAA);
          end
        end
      end
      ST_WSET: begin
        if (tmr_last) begin
          st_nxt   = ST_WPULSE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(NP);
        end
      end
      ST_WPULSE: begin
        if (tmr_last) begin
          st_nxt   = ST_WREC;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(1);
        end
      end
      ST_WREC: begin
        if (tmr_last) begin
          if (HAS_GAP_W) begin
            st_nxt   = ST_GAP;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(NGAP_W);
          end else begin
            st_nxt = ST_IDLE;
            done   = 1'b1;
          end
        end
      end
      ST_RD: begin
        if (tmr_last) begin
          if (HAS_GAP_R) begin
            st_nxt   = ST_GAP;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(NGAP_R);
          end else begin
            st_nxt = ST_IDLE;
            done   = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (tmr_last) begin
          st_nxt = ST_IDLE;
          done   = 1'b1;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4,
  parameter int NP     = 23,
  parameter int NWZ    = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  seq_st_t           st,
  input  logic [CNT_W-1:0]  tmr_cnt,
  input  logic              rd_cap,
  input  logic              done,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  // Driver switches on once the strobe has been low for NWZ cycles.
  localparam int OE_FROM = NP - NWZ;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= done;
      if (rd_cap) rsp_rdata <= mem_dq_in;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_cs_n   = !((st == ST_WSET) || (st == ST_WPULSE) ||
                        (st == ST_WREC) || (st == ST_RD));
  assign mem_we_n   = (st != ST_WPULSE);
  assign mem_dq_oe  = (st == ST_WPULSE) && (tmr_cnt <= CNT_W'(OE_FROM));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 4,
  parameter int CLK_NS   = 8,
  parameter int T_CYC_NS = 200,
  parameter int T_WP_NS  = 180,
  parameter int T_AW_NS  = 180,
  parameter int T_DW_NS  = 120,
  parameter int T_WZ_NS  = 60,
  parameter int T_AA_NS  = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int NCYC   = ns_to_cyc(T_CYC_NS, CLK_NS);
  localparam int NWP    = ns_to_cyc(T_WP_NS, CLK_NS);
  localparam int NAW    = ns_to_cyc(T_AW_NS, CLK_NS);
  localparam int NDW    = ns_to_cyc(T_DW_NS, CLK_NS);
  localparam int NWZ    = ns_to_cyc(T_WZ_NS, CLK_NS);
  localparam int NAA    = ns_to_cyc(T_AA_NS, CLK_NS);
  // Strobe covers pulse width, turn-off plus data setup, and address-valid
  // time (one setup cycle already precedes the strobe).
  localparam int NP     = max2(max2(NWP, NWZ + NDW), NAW - 1);
  localparam int NACT_W = NP + 2;
  localparam int NGAP_W = (NCYC > NACT_W) ? NCYC - NACT_W : 0;
  localparam int NGAP_R = (NCYC > NAA) ? NCYC - NAA : 0;
  localparam int NMAX   = max2(max2(NP, NAA), max2(NGAP_W, NGAP_R));
  localparam int CNT_W  = $clog2(NMAX + 1);

  seq_st_t          st;
  logic             accept;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic [CNT_W-1:0] tmr_cnt;
  logic             tmr_last;
  logic             rd_cap;
  logic             done;

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .cnt      (tmr_cnt),
    .last     (tmr_last)
  );

  sram_ctl_seq #(
    .NP(NP), .NAA(NAA), .NGAP_W(NGAP_W), .NGAP_R(NGAP_R), .CNT_W(CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .tmr_last  (tmr_last),
    .st        (st),
    .req_ready (req_ready),
    .accept    (accept),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .rd_cap    (rd_cap),
    .done      (done)
  );

  sram_ctl_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NP(NP), .NWZ(NWZ), .CNT_W(CNT_W)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .st         (st),
    .tmr_cnt    (tmr_cnt),
    .rd_cap     (rd_cap),
    .done       (done),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_out (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int CLK_NS  = 8,
  parameter int T_WP_NS = 180,
  parameter int T_AW_NS = 180,
  parameter int T_DW_NS = 120,
  parameter int T_WZ_NS = 60
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);

  localparam int C_WZ = ns_to_cyc(T_WZ_NS, CLK_NS);
  localparam int C_P  = max2(max2(ns_to_cyc(T_WP_NS, CLK_NS),
                                  C_WZ + ns_to_cyc(T_DW_NS, CLK_NS)),
                             ns_to_cyc(T_AW_NS, CLK_NS) - 1);

  logic [15:0] we_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        we_lo_cnt <= '0;
    else if (mem_we_n) we_lo_cnt <= '0;
    else               we_lo_cnt <= we_lo_cnt + 16'd1;
  end

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n) else $error("idle without standby"); // R2

  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n) else $error("strobe without select"); // R4

  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt == 16'(C_P))) else $error("pulse length"); // R4

  AST_OE_INSIDE_WE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n) else $error("driver on outside strobe"); // R5

  AST_OE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (we_lo_cnt == 16'(C_WZ))) else $error("driver on early"); // R5

  AST_OE_OFF_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $fell(mem_dq_oe)) else $error("driver late off"); // R5

  AST_ADDR_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> (mem_we_n && $past(mem_we_n))) else $error("addr moved"); // R6

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid) else $error("long ack"); // R8

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready) else $error("ready after accept"); // R8

endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W(ADDR_W), .CLK_NS(CLK_NS), .T_WP_NS(T_WP_NS), .T_AW_NS(T_AW_NS),
  .T_DW_NS(T_DW_NS), .T_WZ_NS(T_WZ_NS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;

  localparam int CLK = 8;
  localparam real T_AA = 200.0;
  localparam real T_WZ = 60.0;
  localparam real T_DW = 120.0;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  int nwz, np, ncyc, naa, w_lat, r_lat;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [9:0] req_addr = '0;
  logic [3:0] req_wdata = '0;
  logic       req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_dq_oe;
  logic [3:0] rsp_rdata, mem_dq_out, mem_dq_in, mem_q;
  logic [9:0] mem_addr;
  logic       mem_drv;

  always #(CLK/2) clk = ~clk;

  sram_ctl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- timed memory model, polled every 1 ns ----------------
  logic [3:0] mem [1024];
  real  t_acc, t_wf, t_dat;
  logic [9:0] p_addr, w_addr;
  logic p_cs_n = 1'b1, p_we_n = 1'b1, p_oe = 1'b0, p_wr = 1'b0, w_has = 1'b0;
  logic [3:0] p_dq, snap;

  assign mem_drv   = !mem_cs_n && mem_we_n;
  assign mem_dq_in = mem_dq_oe ? mem_dq_out : (mem_drv ? mem_q : 4'h0);

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 4'h0;
    t_acc = 0.0; t_wf = 0.0; t_dat = 0.0;
    p_addr = '0; w_addr = '0; p_dq = '0; snap = '0; mem_q = '0;
    #0.5;
    forever begin
      real t;
      logic wr_now;
      t = $realtime;
      wr_now = !mem_cs_n && !mem_we_n;
      if (mem_addr !== p_addr) begin
        t_acc = t;
        if (!mem_we_n || !p_we_n) chk(1'b0, "R6", int'(mem_we_n), 1);
      end
      if (!mem_cs_n && p_cs_n) t_acc = t;
      if (wr_now && !p_wr) begin t_wf = t; w_addr = mem_addr; w_has = 1'b0; end
      if (wr_now && mem_addr !== w_addr) chk(1'b0, "R6", int'(mem_addr), int'(w_addr));
      if (mem_dq_oe && mem_drv) chk(1'b0, "R5", 1, 0);
      if (mem_dq_oe && wr_now && (t - t_wf) < T_WZ) chk(1'b0, "R5", int'(t - t_wf), 60);
      if (mem_dq_oe && (!p_oe || mem_dq_out !== p_dq)) t_dat = t;
      if (wr_now && mem_dq_oe) begin snap = mem_dq_out; w_has = 1'b1; end
      if (!wr_now && p_wr) begin
        chk(int'(t - t_wf) == np * CLK, "R4", int'(t - t_wf), np * CLK);
        chk(w_has && (t - t_dat) >= T_DW, "R5", int'(t - t_dat), 120);
        mem[w_addr] = snap;
      end
      // data poisoned (inverted) until the access time has elapsed
      mem_q = ((t - t_acc) >= T_AA - 2.0) ? mem[mem_addr] : ~mem[mem_addr];
      p_addr = mem_addr; p_cs_n = mem_cs_n; p_we_n = mem_we_n;
      p_oe = mem_dq_oe; p_dq = mem_dq_out; p_wr = wr_now;
      #1;
    end
  end

  // ---------------- host driver ----------------
  task automatic do_req(input bit wr, input int a, input int d,
                        output int rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a[9:0]; req_wdata = d[3:0];
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid) begin
      if (req_ready) chk(1'b0, "R8", 1, 0);
      @(negedge clk);
      lat++;
    end
    rd = int'(rsp_rdata);
    chk(req_ready && mem_cs_n, "R2", int'(mem_cs_n), 1);
    @(negedge clk);
    chk(!rsp_valid, "R8", int'(rsp_valid), 0);
  endtask

  function automatic int pat(input int a, input int k);
    return ((a * 7 + 3 + k) ^ (a >> 4) ^ (a >> 8)) & 15;
  endfunction

  initial begin
    int rd, lat, lo;
    nwz   = cyc(60);
    np    = mx(mx(cyc(180), nwz + cyc(120)), cyc(180) - 1);
    ncyc  = cyc(200);
    naa   = cyc(200);
    w_lat = mx(np + 2, ncyc);
    r_lat = mx(naa, ncyc);

    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_we_n && !mem_dq_oe && req_ready && !rsp_valid, "R1",
        int'({mem_cs_n, mem_we_n, mem_dq_oe, req_ready, rsp_valid}), 5'b11010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_cs_n && mem_we_n && !mem_dq_oe && req_ready && !rsp_valid, "R1",
        int'({mem_cs_n, mem_we_n, mem_dq_oe, req_ready, rsp_valid}), 5'b11010);

    // full sweep: write every address, then read every address (R3, R4, R7)
    for (int a = 0; a < 1024; a++) begin
      do_req(1'b1, a, pat(a, 0), rd, lat);
      if (a < 8) chk(lat == w_lat, "R4", lat, w_lat);
    end
    for (int a = 0; a < 1024; a++) begin
      do_req(1'b0, a, 0, rd, lat);
      chk(rd == pat(a, 0), "R3", rd, pat(a, 0));
      chk(lat == r_lat, "R7", lat, r_lat);
    end

    // overwrite the edges of the address space with other values (R3)
    for (int a = 0; a < 16; a++) begin
      do_req(1'b1, a, pat(a, 5), rd, lat);
      do_req(1'b1, 1023 - a, pat(1023 - a, 9), rd, lat);
    end
    for (int a = 0; a < 16; a++) begin
      do_req(1'b0, a, 0, rd, lat);
      chk(rd == pat(a, 5), "R3", rd, pat(a, 5));
      do_req(1'b0, 1023 - a, 0, rd, lat);
      chk(rd == pat(1023 - a, 9), "R3", rd, pat(1023 - a, 9));
      do_req(1'b0, 16 + a, 0, rd, lat);
      chk(rd == pat(16 + a, 0), "R3", rd, pat(16 + a, 0));
    end

    // back-pressure: second request held valid while the first is in flight
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 10'd300; req_wdata = 4'hA;
    @(posedge clk);
    @(negedge clk);
    req_addr = 10'd301; req_wdata = 4'h5;
    lo = 0;
    while (!req_ready) begin
      @(negedge clk);
      lo++;
    end
    chk(lo == w_lat, "R10", lo, w_lat);
    chk(lo + 1 >= ncyc, "R9", lo + 1, ncyc);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    do_req(1'b0, 300, 0, rd, lat);
    chk(rd == 10, "R10", rd, 10);
    do_req(1'b0, 301, 0, rd, lat);
    chk(rd == 5, "R10", rd, 5);

    // back-to-back reads: acceptances spaced by at least a cycle time
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 10'd7;
    @(posedge clk);
    lo = 0;
    @(negedge clk);
    while (!req_ready) begin
      @(negedge clk);
      lo++;
    end
    chk(lo + 1 >= ncyc, "R9", lo + 1, ncyc);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk(int'(rsp_rdata) == pat(7, 5), "R7", int'(rsp_rdata), pat(7, 5));

    repeat (5) @(negedge clk);
    chk(mem_cs_n && req_ready, "R2", int'(mem_cs_n), 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule